// File: doc/BRIEF.md
# Hidden Configuration Register Access Controller

This block sits between a host's I/O accesses to an eight-byte disk command window and the task-file port behind it. It normally forwards every access unchanged. A driver reaches a hidden bank of drive timing registers without a separate address space. It does two wide reads of the error register, then writes an unlock byte to the sector-count offset. From then on, byte writes to certain offsets land in the bank instead of the task file. A relock byte written to the same gate offset closes the bank again.

The bank holds read-cycle and write-cycle timing for each of the two devices on the channel, a control byte, a strap shadow byte and a miscellaneous byte. The miscellaneous byte selects the target device and holds the address-setup code. That code is shared by both devices, so software programs the slower one. Until the control byte holds the override value, the timing outputs show safe PIO-0 defaults for the clock-speed strap latched at reset. A probe returns the strap bit: write 0xFF to offset 5, then do an immediate wide read of offset 5.

The host side is a valid/ready stream. The host holds `acc_valid` and its payload until `acc_ready` is high at a clock edge. A forwarded access shows on the `tf_*` side in the same cycle, and its `acc_ready` follows `tf_ready`. An access the block absorbs is accepted at once, with `tf_valid` held low. Read data is valid in the cycle the access is accepted.

Top module: `trapdoor_cfg_port`

## Requirements
- R1: During reset the strap input is latched. After reset the bank is closed and the override is off. Both timing outputs of both devices show the default data timing for that strap (0x6B for strap 0, 0x58 for strap 1). The setup code is 3 for strap 0 and 2 for strap 1. The device select and the strap shadow are 0.
- R2: The bank opens (`cfg_open` high from the next cycle) after three accepted accesses in a row: two wide reads at offset 1, then a byte write of 3 to offset 2. The two reads are forwarded and the unlock write is absorbed.
- R3: Any other accepted access after the first or second arming read drops the block back to the closed state. The unlock write after such a break is forwarded and leaves the bank closed.
- R4: While the bank is closed, every access except a strap probe read is forwarded unchanged, and no bank content or timing output changes.
- R5: While the bank is open, byte writes are absorbed and stored by offset. Offset 0 is read timing and offset 1 is write timing, both for the selected device. Offset 3 is control, offset 5 is the strap shadow and offset 6 is miscellaneous.
- R6: Bit 0 of the miscellaneous write selects the device (0 or 1) that receives timing writes and drives `sel_dev`. Bits 5:4 form the setup code.
- R7: A byte write of 0x83 to offset 2 while open is absorbed and closes the bank from the next cycle. Later byte writes to offset 0 are forwarded.
- R8: When control equals 0x85, `timing_override` is high. `rd_timing`/`wr_timing` (device 1 in bits 15:8, device 0 in bits 7:0) and `setup_code` then show the programmed values. Otherwise they show the strap defaults of R1.
- R9: A byte write of 0xFF to offset 5 arms a probe, in either state. If the next accepted access is a wide read of offset 5, it is absorbed and returns the latched strap in bit 0 with zeros above. Any other access disarms the probe.
- R10: A forwarded access drives `tf_valid` from `acc_valid` and completes only when `tf_ready` is high; it returns `tf_rdata`. An absorbed access is accepted in its first cycle with `tf_valid` low. Absorbed writes read as zero.
- R11: While open, reads, wide writes and byte writes to offsets 4 and 7 are forwarded. Byte writes to offset 2 with any value other than 0x83 are absorbed, ignored, and keep the bank open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampled while low |
| strap_in | input | 1 | Clock-speed strap pin |
| acc_valid | input | 1 | Host access valid |
| acc_ready | output | 1 | Host access accepted this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_addr | input | 3 | Byte offset in the command window |
| acc_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| acc_rdata | output | 16 | Read data, valid when the access is accepted |
| tf_valid | output | 1 | Forwarded access valid |
| tf_ready | input | 1 | Task-file port accepts the forwarded access |
| tf_write | output | 1 | Forwarded direction |
| tf_wide | output | 1 | Forwarded width |
| tf_addr | output | 3 | Forwarded offset |
| tf_wdata | output | 16 | Forwarded write data |
| tf_rdata | input | 16 | Task-file read data |
| cfg_open | output | 1 | Hidden bank open |
| timing_override | output | 1 | Programmed timings in force |
| rd_timing | output | 16 | Effective read-cycle timing, one byte per device |
| wr_timing | output | 16 | Effective write-cycle timing, one byte per device |
| setup_code | output | 2 | Effective shared address-setup code |
| sel_dev | output | 1 | Device selected for timing writes |
| strap_shadow | output | 8 | Stored strap shadow byte |

## Verification
Some checks run on every cycle. The bank only opens straight after an accepted unlock write, and a relock always closes it. Nothing in the bank moves while it is closed. Absorbed reads return only bit 0, and a stalled forwarded access stays presented. Other behaviour needs the bench's scenarios. These are the exact arming order and the ways a sequence can break, per-device routing through the select bit, the override gate, probe arming and disarming, and the strap defaults after resets with each strap value.

// File: rtl/trapdoor_pkg.sv
package trapdoor_pkg;
  localparam int TD_ADDR_W = 3;
  localparam int TD_DATA_W = 16;
  localparam int TD_BYTE_W = 8;
  localparam int TD_NUM_OFS = 1 << TD_ADDR_W;

  typedef enum logic [1:0] {
    TD_LOCKED = 2'd0,
    TD_ARM1   = 2'd1,
    TD_ARM2   = 2'd2,
    TD_OPEN   = 2'd3
  } td_state_e;
endpackage

// File: rtl/trapdoor_seq.sv
module trapdoor_seq
  import trapdoor_pkg::*;
#(
  parameter logic [TD_ADDR_W-1:0]  ERR_OFS    = 3'd1,
  parameter logic [TD_ADDR_W-1:0]  GATE_OFS   = 3'd2,
  parameter logic [TD_ADDR_W-1:0]  PROBE_OFS  = 3'd5,
  parameter logic [TD_BYTE_W-1:0]  UNLOCK_VAL = 8'h03,
  parameter logic [TD_BYTE_W-1:0]  RELOCK_VAL = 8'h83,
  parameter logic [TD_BYTE_W-1:0]  PROBE_VAL  = 8'hFF,
  parameter logic [TD_NUM_OFS-1:0] REG_MASK   = 8'b0110_1011
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 acc_write,
  input  logic                 acc_wide,
  input  logic [TD_ADDR_W-1:0] acc_addr,
  input  logic [TD_BYTE_W-1:0] acc_byte,
  output logic                 cfg_open,
  output logic                 route_local,
  output logic                 probe_hit,
  output logic                 bank_we
);
  td_state_e state_q, state_d;
  logic      probe_q, probe_d;
  logic      byte_wr, arm_rd, gate_wr, unlock_hit, relock_hit;

  always_comb begin
    byte_wr    = acc_write & ~acc_wide;
    arm_rd     = ~acc_write & acc_wide & (acc_addr == ERR_OFS);
    gate_wr    = byte_wr & (acc_addr == GATE_OFS);
    unlock_hit = (state_q == TD_ARM2) & gate_wr & (acc_byte == UNLOCK_VAL);
    relock_hit = (state_q == TD_OPEN) & gate_wr & (acc_byte == RELOCK_VAL);
    bank_we    = (state_q == TD_OPEN) & byte_wr & REG_MASK[acc_addr];
    probe_hit  = probe_q & ~acc_write & acc_wide & (acc_addr == PROBE_OFS);
    route_local = unlock_hit | ((state_q == TD_OPEN) & gate_wr) | bank_we | probe_hit;
  end

  always_comb begin
    state_d = state_q;
    probe_d = probe_q;
    if (fire) begin
      probe_d = byte_wr & (acc_addr == PROBE_OFS) & (acc_byte == PROBE_VAL);
      unique case (state_q)
        TD_LOCKED: state_d = arm_rd ? TD_ARM1 : TD_LOCKED;
        TD_ARM1:   state_d = arm_rd ? TD_ARM2 : TD_LOCKED;
        TD_ARM2:   state_d = unlock_hit ? TD_OPEN : TD_LOCKED;
        TD_OPEN:   state_d = relock_hit ? TD_LOCKED : TD_OPEN;
        default:   state_d = TD_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TD_LOCKED;
      probe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      probe_q <= probe_d;
    end
  end

  assign cfg_open = (state_q == TD_OPEN);
endmodule

// File: rtl/trapdoor_bank.sv
module trapdoor_bank
  import trapdoor_pkg::*;
#(
  parameter int                   NUM_DEV    = 2,
  parameter logic [TD_ADDR_W-1:0] RD_OFS     = 3'd0,
  parameter logic [TD_ADDR_W-1:0] WR_OFS     = 3'd1,
  parameter logic [TD_ADDR_W-1:0] CTRL_OFS   = 3'd3,
  parameter logic [TD_ADDR_W-1:0] SHADOW_OFS = 3'd5,
  parameter logic [TD_ADDR_W-1:0] MISC_OFS   = 3'd6,
  parameter int                   SETUP_LSB  = 4,
  parameter int                   SETUP_W    = 2,
  parameter logic [TD_BYTE_W-1:0] OVR_VAL    = 8'h85,
  parameter logic [TD_BYTE_W-1:0] DATA_SLOW  = 8'h6B,
  parameter logic [TD_BYTE_W-1:0] DATA_FAST  = 8'h58,
  parameter logic [SETUP_W-1:0]   SETUP_SLOW = 2'd3,
  parameter logic [SETUP_W-1:0]   SETUP_FAST = 2'd2,
  localparam int                  DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int                  OUT_W      = NUM_DEV * TD_BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_in,
  input  logic                 we,
  input  logic [TD_ADDR_W-1:0] wr_addr,
  input  logic [TD_BYTE_W-1:0] wr_byte,
  output logic                 strap_q,
  output logic [OUT_W-1:0]     rd_timing,
  output logic [OUT_W-1:0]     wr_timing,
  output logic [SETUP_W-1:0]   setup_code,
  output logic [DEV_W-1:0]     sel_dev,
  output logic                 override,
  output logic [TD_BYTE_W-1:0] shadow
);
  logic [TD_BYTE_W-1:0] ctrl_q;
  logic [DEV_W-1:0]     sel_q;
  logic [SETUP_W-1:0]   setup_q;
  logic [TD_BYTE_W-1:0] def_data, reset_data;
  logic [SETUP_W-1:0]   def_setup;

  assign reset_data = strap_in ? DATA_FAST : DATA_SLOW;
  assign def_data   = strap_q ? DATA_FAST : DATA_SLOW;
  assign def_setup  = strap_q ? SETUP_FAST : SETUP_SLOW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_in;
      ctrl_q  <= '0;
      sel_q   <= '0;
      setup_q <= '0;
      shadow  <= '0;
    end else if (we) begin
      if (wr_addr == CTRL_OFS)   ctrl_q <= wr_byte;
      if (wr_addr == SHADOW_OFS) shadow <= wr_byte;
      if (wr_addr == MISC_OFS) begin
        sel_q   <= wr_byte[DEV_W-1:0];
        setup_q <= wr_byte[SETUP_LSB +: SETUP_W];
      end
    end
  end

  assign override   = (ctrl_q == OVR_VAL);
  assign sel_dev    = sel_q;
  assign setup_code = override ? setup_q : def_setup;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic [TD_BYTE_W-1:0] rd_q, wr_q;
    logic                 dev_hit;
    assign dev_hit = we & (sel_q == DEV_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_q <= reset_data;
        wr_q <= reset_data;
      end else begin
        if (dev_hit && wr_addr == RD_OFS) rd_q <= wr_byte;
        if (dev_hit && wr_addr == WR_OFS) wr_q <= wr_byte;
      end
    end

    assign rd_timing[g*TD_BYTE_W +: TD_BYTE_W] = override ? rd_q : def_data;
    assign wr_timing[g*TD_BYTE_W +: TD_BYTE_W] = override ? wr_q : def_data;
  end
endmodule

// File: rtl/trapdoor_cfg_port.sv
module trapdoor_cfg_port
  import trapdoor_pkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int OUT_W  = NUM_DEV * TD_BYTE_W,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_in,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic                 acc_write,
  input  logic                 acc_wide,
  input  logic [TD_ADDR_W-1:0] acc_addr,
  input  logic [TD_DATA_W-1:0] acc_wdata,
  output logic [TD_DATA_W-1:0] acc_rdata,
  output logic                 tf_valid,
  input  logic                 tf_ready,
  output logic                 tf_write,
  output logic                 tf_wide,
  output logic [TD_ADDR_W-1:0] tf_addr,
  output logic [TD_DATA_W-1:0] tf_wdata,
  input  logic [TD_DATA_W-1:0] tf_rdata,
  output logic                 cfg_open,
  output logic                 timing_override,
  output logic [OUT_W-1:0]     rd_timing,
  output logic [OUT_W-1:0]     wr_timing,
  output logic [1:0]           setup_code,
  output logic [DEV_W-1:0]     sel_dev,
  output logic [TD_BYTE_W-1:0] strap_shadow
);
  logic route_local, probe_hit, bank_we, fire, strap_q;

  assign acc_ready = route_local | tf_ready;
  assign fire      = acc_valid & acc_ready;
  assign tf_valid  = acc_valid & ~route_local;
  assign tf_write  = acc_write;
  assign tf_wide   = acc_wide;
  assign tf_addr   = acc_addr;
  assign tf_wdata  = acc_wdata;

  always_comb begin
    if (!route_local)   acc_rdata = tf_rdata;
    else if (probe_hit) acc_rdata = {{(TD_DATA_W-1){1'b0}}, strap_q};
    else                acc_rdata = '0;
  end

  trapdoor_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .acc_write  (acc_write),
    .acc_wide   (acc_wide),
    .acc_addr   (acc_addr),
    .acc_byte   (acc_wdata[TD_BYTE_W-1:0]),
    .cfg_open   (cfg_open),
    .route_local(route_local),
    .probe_hit  (probe_hit),
    .bank_we    (bank_we)
  );

  trapdoor_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_in  (strap_in),
    .we        (fire & bank_we),
    .wr_addr   (acc_addr),
    .wr_byte   (acc_wdata[TD_BYTE_W-1:0]),
    .strap_q   (strap_q),
    .rd_timing (rd_timing),
    .wr_timing (wr_timing),
    .setup_code(setup_code),
    .sel_dev   (sel_dev),
    .override  (timing_override),
    .shadow    (strap_shadow)
  );
endmodule

// File: rtl/trapdoor_chk.sv
module trapdoor_chk #(
  parameter int          OUT_W      = 16,
  parameter logic [2:0]  GATE_OFS   = 3'd2,
  parameter logic [7:0]  UNLOCK_VAL = 8'h03,
  parameter logic [7:0]  RELOCK_VAL = 8'h83
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             acc_write,
  input logic             acc_wide,
  input logic [2:0]       acc_addr,
  input logic [7:0]       acc_byte,
  input logic [15:0]      acc_rdata,
  input logic             tf_valid,
  input logic             tf_ready,
  input logic             cfg_open,
  input logic             timing_override,
  input logic [OUT_W-1:0] rd_timing,
  input logic [OUT_W-1:0] wr_timing,
  input logic [1:0]       setup_code,
  input logic [7:0]       strap_shadow
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r2_open_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $rose(cfg_open) |->
      $past(acc_valid && acc_ready && acc_write && !acc_wide &&
            acc_addr == GATE_OFS && acc_byte == UNLOCK_VAL));

  a_r7_relock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && cfg_open && acc_write && !acc_wide &&
    acc_addr == GATE_OFS && acc_byte == RELOCK_VAL |=> !cfg_open);

  a_r4_closed_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !cfg_open |=> $stable(rd_timing) && $stable(wr_timing) &&
      $stable(strap_shadow) && $stable(setup_code) && $stable(timing_override));

  a_r9_local_read_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && !tf_valid && !acc_write |-> acc_rdata[15:1] == 15'd0);

  a_r10_local_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !tf_valid |-> acc_ready);

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    tf_valid && !tf_ready |=> tf_valid);
endmodule

bind trapdoor_cfg_port trapdoor_chk #(.OUT_W(OUT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_ready      (acc_ready),
  .acc_write      (acc_write),
  .acc_wide       (acc_wide),
  .acc_addr       (acc_addr),
  .acc_byte       (acc_wdata[7:0]),
  .acc_rdata      (acc_rdata),
  .tf_valid       (tf_valid),
  .tf_ready       (tf_ready),
  .cfg_open       (cfg_open),
  .timing_override(timing_override),
  .rd_timing      (rd_timing),
  .wr_timing      (wr_timing),
  .setup_code     (setup_code),
  .strap_shadow   (strap_shadow)
);

// File: tb/trapdoor_cfg_port_test.sv
module trapdoor_cfg_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_in = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        acc_ready;
  logic [15:0] acc_rdata;
  logic        tf_valid, tf_write, tf_wide;
  logic        tf_ready = 1'b0;
  logic [2:0]  tf_addr;
  logic [15:0] tf_wdata;
  logic [15:0] tf_rdata = '0;
  logic        cfg_open, timing_override, sel_dev;
  logic [15:0] rd_timing, wr_timing;
  logic [1:0]  setup_code;
  logic [7:0]  strap_shadow;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // bench model, built from the requirements
  int         m_state;
  logic       m_probe, m_strap, m_sel;
  logic [7:0] m_rd [2];
  logic [7:0] m_wr [2];
  logic [7:0] m_ctrl, m_shadow;
  logic [1:0] m_setup;

  trapdoor_cfg_port uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] def_data(input logic s);
    return s ? 8'h58 : 8'h6B;
  endfunction

  function automatic logic exp_fwd(input logic w, input logic wd, input logic [2:0] a, input logic [7:0] b);
    if (m_probe && !w && wd && a == 3'd5) return 1'b0;
    if (m_state == 3 && w && !wd && (a inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6})) return 1'b0;
    if (m_state == 2 && w && !wd && a == 3'd2 && b == 8'h03) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_update(input logic w, input logic wd, input logic [2:0] a, input logic [7:0] b);
    logic arm, bw;
    arm = !w && wd && a == 3'd1;
    bw  = w && !wd;
    case (m_state)
      0: m_state = arm ? 1 : 0;
      1: m_state = arm ? 2 : 0;
      2: m_state = (bw && a == 3'd2 && b == 8'h03) ? 3 : 0;
      default: begin
        if (bw && a == 3'd2 && b == 8'h83) m_state = 0;
        else if (bw) begin
          case (a)
            3'd0: m_rd[m_sel] = b;
            3'd1: m_wr[m_sel] = b;
            3'd3: m_ctrl = b;
            3'd5: m_shadow = b;
            3'd6: begin m_sel = b[0]; m_setup = b[5:4]; end
            default: ;
          endcase
        end
      end
    endcase
    m_probe = bw && a == 3'd5 && b == 8'hFF;
  endtask

  task automatic check_outputs();
    logic ovr;
    ovr = (m_ctrl == 8'h85);
    check("R2/R3/R7 cfg_open", cfg_open, m_state == 3);
    check("R8 timing_override", timing_override, ovr);
    check("R5/R8 rd_timing", rd_timing, ovr ? {m_rd[1], m_rd[0]} : {2{def_data(m_strap)}});
    check("R5/R8 wr_timing", wr_timing, ovr ? {m_wr[1], m_wr[0]} : {2{def_data(m_strap)}});
    check("R6/R8 setup_code", setup_code, ovr ? m_setup : (m_strap ? 2'd2 : 2'd3));
    check("R6 sel_dev", sel_dev, m_sel);
    check("R5 strap_shadow", strap_shadow, m_shadow);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap_in = s; acc_valid = 1'b0; tf_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap_in = ~s;   // latched value must hold after reset
    m_state = 0; m_probe = 0; m_strap = s; m_sel = 0; m_setup = 0;
    m_ctrl = 0; m_shadow = 0;
    for (int i = 0; i < 2; i++) begin m_rd[i] = def_data(s); m_wr[i] = def_data(s); end
    #1;
    check("R1 reset closed", cfg_open, 1'b0);
    check("R1 reset override", timing_override, 1'b0);
    check("R1 reset rd_timing", rd_timing, {2{def_data(s)}});
    check("R1 reset wr_timing", wr_timing, {2{def_data(s)}});
    check("R1 reset setup_code", setup_code, s ? 2'd2 : 2'd3);
    check("R1 reset sel/shadow", {sel_dev, strap_shadow}, 9'd0);
  endtask

  task automatic acc(input logic w, input logic wd, input logic [2:0] a, input logic [15:0] d, input int stall);
    logic        fwd;
    logic [15:0] trd, erd;
    fwd = exp_fwd(w, wd, a, d[7:0]);
    trd = 16'($urandom);
    if (fwd) erd = trd;
    else if (m_probe && !w && wd && a == 3'd5) erd = {15'd0, m_strap};
    else erd = 16'd0;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_wide = wd; acc_addr = a; acc_wdata = d;
    tf_rdata = trd; tf_ready = (stall == 0);
    #1;
    check("R4/R10/R11 routing", tf_valid, fwd);
    if (fwd) check("R4 forwarded payload", {tf_write, tf_wide, tf_addr, tf_wdata}, {w, wd, a, d});
    if (stall > 0) begin
      check("R10 ready under stall", acc_ready, !fwd);
      if (fwd) begin
        repeat (stall) @(negedge clk);
        #1;
        check("R10 held during stall", tf_valid, 1'b1);
        tf_ready = 1'b1;
        #1;
      end
    end
    check("R10 accepted", acc_ready, 1'b1);
    if (!w) check("R9/R10 read data", acc_rdata, erd);
    @(posedge clk);
    #1;
    acc_valid = 1'b0; tf_ready = 1'b0;
    model_update(w, wd, a, d[7:0]);
    check_outputs();
  endtask

  task automatic unlock();
    acc(1'b0, 1'b1, 3'd1, 16'h0, 0);
    acc(1'b0, 1'b1, 3'd1, 16'h0, 0);
    acc(1'b1, 1'b0, 3'd2, 16'h0003, 0);
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] b);
    acc(1'b1, 1'b0, a, {8'h00, b}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);

    // R2 unlock and R5/R6/R8 programming
    unlock();
    check("R2 open after unlock", cfg_open, 1'b1);
    bwr(3'd6, 8'h00); bwr(3'd0, 8'h56); bwr(3'd1, 8'h44);
    bwr(3'd6, 8'h01); bwr(3'd0, 8'h42); bwr(3'd1, 8'h32);
    check("R8 defaults before override", rd_timing, 16'h6B6B);
    check("R6 device 1 selected", sel_dev, 1'b1);
    bwr(3'd6, 8'h20); bwr(3'd3, 8'h85);
    check("R5/R6 rd per device", rd_timing, 16'h4256);
    check("R5/R6 wr per device", wr_timing, 16'h3244);
    check("R8 setup code", setup_code, 2'd2);

    // R11 forwarding while open
    acc(1'b0, 1'b1, 3'd0, 16'h0, 0);
    acc(1'b1, 1'b1, 3'd0, 16'h1234, 0);
    bwr(3'd4, 8'h11); bwr(3'd7, 8'h22);
    bwr(3'd2, 8'h55);
    check("R11 stray gate write keeps open", cfg_open, 1'b1);

    // R7 relock, then R4 locked pass-through
    bwr(3'd2, 8'h83);
    check("R7 closed after relock", cfg_open, 1'b0);
    bwr(3'd0, 8'h99);
    check("R4 bank untouched while closed", rd_timing, 16'h4256);

    // R3 broken sequences
    acc(1'b0, 1'b1, 3'd1, 16'h0, 0); bwr(3'd2, 8'h03);
    check("R3 one read is not enough", cfg_open, 1'b0);
    acc(1'b0, 1'b1, 3'd1, 16'h0, 0); acc(1'b0, 1'b1, 3'd1, 16'h0, 0);
    acc(1'b0, 1'b0, 3'd7, 16'h0, 0); bwr(3'd2, 8'h03);
    check("R3 intervening read breaks", cfg_open, 1'b0);
    acc(1'b0, 1'b1, 3'd1, 16'h0, 0); acc(1'b0, 1'b1, 3'd1, 16'h0, 0);
    bwr(3'd2, 8'h04);
    check("R3 wrong unlock value", cfg_open, 1'b0);

    // R9 strap probe
    bwr(3'd5, 8'hFF); acc(1'b0, 1'b1, 3'd5, 16'h0, 0);
    bwr(3'd5, 8'hFF); bwr(3'd4, 8'h00); acc(1'b0, 1'b1, 3'd5, 16'h0, 0);

    // R10 stalls on forwarded and absorbed accesses
    acc(1'b0, 1'b1, 3'd3, 16'h0, 3);
    unlock();
    acc(1'b1, 1'b0, 3'd0, 16'h0077, 2);
    acc(1'b1, 1'b1, 3'd6, 16'hABCD, 4);

    // random phase, both straps
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(pass[0] ? 1'b1 : 1'b0);
      for (int n = 0; n < 500; n++) begin
        int kind;
        kind = $urandom_range(0, 7);
        case (kind)
          0, 1: unlock();
          2: bwr(3'd2, ($urandom_range(0, 3) == 0) ? 8'h83 : 8'($urandom));
          3: begin bwr(3'd5, 8'hFF); acc(1'b0, 1'b1, 3'd5, 16'h0, 0); end
          4: bwr(3'($urandom_range(0, 7)), 8'($urandom));
          5: bwr(3'd3, ($urandom_range(0, 1) == 0) ? 8'h85 : 8'($urandom));
          6: bwr(3'd6, 8'($urandom));
          default: acc(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom),
                       $urandom_range(0, 2));
        endcase
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule